// File: doc/BRIEF.md
# Time and Calendar Update Engine

This block holds a wall-clock count from seconds up to a two-digit year and advances it by one second each time a one-second tick arrives. Software sees the count as ten byte registers: seven time/calendar bytes and three alarm bytes (seconds, minutes, hours). The bytes are presented either as plain binary or as packed BCD. Hours are shown in 24-hour form or in 12-hour form with a PM flag. Inside, the count is always kept in binary 24-hour form. It is converted to the user encoding on every update and converted back when software loads a new time.

The design keeps two copies. The internal counter always advances on a tick. The user-visible image follows it only while the freeze control is low. Software raises freeze, writes new time bytes, and lowers freeze. On the first cycle after freeze falls, the written image is decoded into the internal counter, if any time byte was written. Every update compares the new time with the alarm bytes. An alarm byte with its top two bits set matches any value. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn. The register port has no handshake and no back-pressure: a write is taken in the cycle it is presented, and a read returns the addressed byte combinationally.

Top module: `rtc_update_engine`

## Requirements
- R1: With `bin_mode`=1 and `hr24`=1, each accepted tick moves seconds 0..59 and minutes 0..59 with carry, and hours 0..23 with carry into the day.
- R2: When hours wrap from 23 to 0, several fields advance. Day of week (byte 6) goes 1..7, with 1 = Sunday. Date (byte 7) wraps after the month's last day: 30 for April, June, September and November, and 31 for the other months except February. Month (byte 8) wraps 12 to 1, and year (byte 9) wraps 99 to 0.
- R3: February has 29 days when year mod 4 is 0 and 28 days otherwise.
- R4: With `bin_mode`=0, every time and alarm byte is packed BCD: tens in bits 7:4 and units in bits 3:0.
- R5: With `hr24`=0, the hours byte (byte 4) holds 1..12 in bits 6:0, and bit 7 = 1 means PM. Midnight reads as 12 AM and noon as 12 PM (BCD 0x12 and 0x92).
- R6: While `set_freeze`=1, the user image changes only by software writes. No `update_done` or `alarm_pulse` is issued. The internal count keeps advancing, so after a release with no time-byte write, the next tick shows the time advanced by every tick received.
- R7: Writes to the time bytes (addresses 0, 2, 4, 6, 7, 8, 9) are accepted only while `set_freeze`=1. If any was written, the image is decoded into the internal count on the first cycle after `set_freeze` falls, and a tick in that cycle is dropped. The next tick then advances from the written time.
- R8: `update_done` is high for exactly the one cycle after each tick taken with `set_freeze`=0, and the user image already holds the new time in that cycle.
- R9: `alarm_pulse` is high together with `update_done` when each of the alarm bytes (addresses 1, 3, 5) equals the new seconds, minutes and hours byte respectively, or has bits 7:6 = 11.
- R10: With `dst_en`=1, in month 4 on a Sunday with date 1..7, the tick after 01:59:59 gives 03:00:00.
- R11: With `dst_en`=1, in month 10 on a Sunday with date 25..31, the first tick after 01:59:59 gives 01:00:00. The fallback is then blocked until the next midnight rollover.
- R12: Addresses 10..15 read 0 and ignore writes. Alarm bytes are writable at any time. Bit 7 of the seconds byte always reads 0.
- R13: After reset the time bytes read sec 00, min 00, hour 00, day 01, date 01, month 01, year 00, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, one per second |
| set_freeze | input | 1 | Freeze user image and allow time-byte writes |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM bit 7 |
| dst_en | input | 1 | Enable daylight-saving jumps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |
| update_done | output | 1 | One-cycle update-ended pulse |

## Verification
A wrong internal count becomes visible on the bytes read back one cycle after the tick that exposes it. The bench compares every time byte after every tick across long runs that cross minute, hour, noon, midnight, month and year boundaries, so a carry or limit error is caught at the first second it matters. A stale freeze, load or fallback flag shows up as a wrong time on the first tick after release or after the trigger time, and the bench checks exactly that tick. A wrong alarm or update pulse is caught in the same cycle, because every pulse is compared against a match the bench computes from its own model bytes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int NREG   = 10;
  localparam int NTIME  = 7;
  localparam int NALARM = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] A_SEC    = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC_AL = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN    = 4'd2;
  localparam logic [ADDR_W-1:0] A_MIN_AL = 4'd3;
  localparam logic [ADDR_W-1:0] A_HR     = 4'd4;
  localparam logic [ADDR_W-1:0] A_HR_AL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DOW    = 4'd6;
  localparam logic [ADDR_W-1:0] A_DATE   = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON    = 4'd8;
  localparam logic [ADDR_W-1:0] A_YR     = 4'd9;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  localparam tod_t TOD_RESET = '{yr: 7'd0, mon: 4'd1, date: 5'd1, dow: 3'd1,
                                 hr: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic byte_t to_code(input logic [6:0] v, input logic bin);
    logic [3:0] tens, ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  function automatic logic [6:0] from_code(input byte_t c, input logic bin);
    return bin ? c[6:0] : 7'(7'(c[7:4]) * 7'd10 + 7'(c[3:0]));
  endfunction

  function automatic byte_t hour_to_code(input logic [4:0] h, input logic bin,
                                         input logic h24);
    logic       pm;
    logic [4:0] h12;
    byte_t      c;
    pm  = (h >= 5'd12);
    h12 = (h == 5'd0) ? 5'd12 : ((h > 5'd12) ? h - 5'd12 : h);
    c   = to_code({2'b00, h12}, bin);
    return h24 ? to_code({2'b00, h}, bin) : {pm, c[6:0]};
  endfunction

  function automatic logic [4:0] hour_from_code(input byte_t c, input logic bin,
                                                input logic h24);
    logic [4:0] h;
    h = 5'(from_code({1'b0, c[6:0]}, bin));
    if (h24)            return h;
    else if (h == 5'd12) return c[7] ? 5'd12 : 5'd0;
    else                return c[7] ? h + 5'd12 : h;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  tod_t cur,
  input  logic dst_en,
  input  logic fall_done,
  output tod_t nxt,
  output logic fall_take,
  output logic midnight
);
  logic end_min, end_hr, spring, fall, end_month;

  always_comb begin
    end_min   = (cur.sec == 6'd59);
    end_hr    = end_min && (cur.min == 6'd59);
    spring    = dst_en && (cur.mon == 4'd4) && (cur.dow == 3'd1) &&
                (cur.date <= 5'd7) && (cur.hr == 5'd1) && end_hr;
    fall      = dst_en && (cur.mon == 4'd10) && (cur.dow == 3'd1) &&
                (cur.date >= 5'd25) && (cur.hr == 5'd1) && end_hr && !fall_done;
    end_month = (cur.date == month_days(cur.mon, cur.yr));
  end

  always_comb begin
    nxt       = cur;
    fall_take = 1'b0;
    midnight  = 1'b0;
    if (!end_min) begin
      nxt.sec = cur.sec + 6'd1;
    end else begin
      nxt.sec = 6'd0;
      if (cur.min != 6'd59) begin
        nxt.min = cur.min + 6'd1;
      end else begin
        nxt.min = 6'd0;
        if (spring) begin
          nxt.hr = 5'd3;
        end else if (fall) begin
          nxt.hr    = 5'd1;
          fall_take = 1'b1;
        end else if (cur.hr != 5'd23) begin
          nxt.hr = cur.hr + 5'd1;
        end else begin
          nxt.hr   = 5'd0;
          midnight = 1'b1;
          nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
          if (!end_month) begin
            nxt.date = cur.date + 5'd1;
          end else begin
            nxt.date = 5'd1;
            if (cur.mon != 4'd12) begin
              nxt.mon = cur.mon + 4'd1;
            end else begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr == 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
  import rtc_pkg::*;
(
  input  tod_t                   t,
  input  logic                   bin,
  input  logic                   h24,
  output byte_t [NTIME-1:0]      img
);
  assign img[0] = to_code({1'b0, t.sec}, bin);
  assign img[1] = to_code({1'b0, t.min}, bin);
  assign img[2] = hour_to_code(t.hr, bin, h24);
  assign img[3] = to_code({4'd0, t.dow}, bin);
  assign img[4] = to_code({2'd0, t.date}, bin);
  assign img[5] = to_code({3'd0, t.mon}, bin);
  assign img[6] = to_code(t.yr, bin);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
#(
  parameter int NFIELD = NALARM
) (
  input  byte_t [NFIELD-1:0] alarm,
  input  byte_t [NFIELD-1:0] now,
  output logic               hit
);
  logic [NFIELD-1:0] field_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign field_ok[i] = (alarm[i][7:6] == 2'b11) || (alarm[i] == now[i]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       set_freeze,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       dst_en,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       alarm_pulse,
  output logic       update_done
);
  localparam logic [NREG-1:0][BYTE_W-1:0] UREG_RESET =
    80'h00_01_01_01_00_00_00_00_00_00;

  tod_t                        tod_q, tod_nxt, tod_ld;
  byte_t [NREG-1:0]            ureg_q;
  byte_t [NTIME-1:0]           img;
  byte_t [NALARM-1:0]          al_bytes, now_bytes;
  logic                        dirty_q, fall_done_q, upd_q, alm_q;
  logic                        fall_take, midnight, hit;
  logic                        load, adv_en, upd;
  logic                        addr_ok, addr_alarm, wr_time_ok, wr_ok;
  byte_t                       wr_byte;

  // Write decode: alarm bytes always, time bytes only while frozen
  assign addr_ok    = (wr_addr < 4'(NREG));
  assign addr_alarm = (wr_addr == A_SEC_AL) || (wr_addr == A_MIN_AL) ||
                      (wr_addr == A_HR_AL);
  assign wr_time_ok = wr_en && addr_ok && !addr_alarm && set_freeze;
  assign wr_ok      = wr_time_ok || (wr_en && addr_alarm);
  assign wr_byte    = (wr_addr == A_SEC) ? {1'b0, wr_data[6:0]} : wr_data;

  // Release of a dirty frozen image loads the internal count
  assign load   = dirty_q && !set_freeze;
  assign adv_en = tick && !load;
  assign upd    = adv_en && !set_freeze;

  always_comb begin
    tod_ld      = TOD_RESET;
    tod_ld.sec  = 6'(from_code(ureg_q[A_SEC], bin_mode));
    tod_ld.min  = 6'(from_code(ureg_q[A_MIN], bin_mode));
    tod_ld.hr   = hour_from_code(ureg_q[A_HR], bin_mode, hr24);
    tod_ld.dow  = 3'(from_code(ureg_q[A_DOW], bin_mode));
    tod_ld.date = 5'(from_code(ureg_q[A_DATE], bin_mode));
    tod_ld.mon  = 4'(from_code(ureg_q[A_MON], bin_mode));
    tod_ld.yr   = from_code(ureg_q[A_YR], bin_mode);
  end

  rtc_advance u_adv (
    .cur       (tod_q),
    .dst_en    (dst_en),
    .fall_done (fall_done_q),
    .nxt       (tod_nxt),
    .fall_take (fall_take),
    .midnight  (midnight)
  );

  rtc_encode u_enc (
    .t   (tod_nxt),
    .bin (bin_mode),
    .h24 (hr24),
    .img (img)
  );

  assign al_bytes[0]  = ureg_q[A_SEC_AL];
  assign al_bytes[1]  = ureg_q[A_MIN_AL];
  assign al_bytes[2]  = ureg_q[A_HR_AL];
  assign now_bytes[0] = img[0];
  assign now_bytes[1] = img[1];
  assign now_bytes[2] = img[2];

  rtc_alarm_cmp #(.NFIELD(NALARM)) u_alarm (
    .alarm (al_bytes),
    .now   (now_bytes),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q       <= TOD_RESET;
      ureg_q      <= UREG_RESET;
      dirty_q     <= 1'b0;
      fall_done_q <= 1'b0;
      upd_q       <= 1'b0;
      alm_q       <= 1'b0;
    end else begin
      if (load)        tod_q <= tod_ld;
      else if (adv_en) tod_q <= tod_nxt;
      if (upd) begin
        ureg_q[A_SEC]  <= img[0];
        ureg_q[A_MIN]  <= img[1];
        ureg_q[A_HR]   <= img[2];
        ureg_q[A_DOW]  <= img[3];
        ureg_q[A_DATE] <= img[4];
        ureg_q[A_MON]  <= img[5];
        ureg_q[A_YR]   <= img[6];
      end
      if (wr_ok) ureg_q[wr_addr] <= wr_byte;
      dirty_q <= set_freeze && (dirty_q || wr_time_ok);
      if (adv_en) begin
        if (fall_take)     fall_done_q <= 1'b1;
        else if (midnight) fall_done_q <= 1'b0;
      end
      upd_q <= upd;
      alm_q <= upd && hit;
    end
  end

  assign rd_data     = (rd_addr < 4'(NREG)) ? ureg_q[rd_addr] : 8'h00;
  assign alarm_pulse = alm_q;
  assign update_done = upd_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && tod_q.sec == 6'd59) |=> (tod_q.sec == 6'd0)); // R1
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    set_freeze |=> !update_done); // R6
  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_freeze && !wr_en) |=> $stable(ureg_q)); // R6
  AST_UPD_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !set_freeze && !dirty_q) |=> update_done); // R8
  AST_ALARM_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> update_done); // R9
endmodule

// File: tb/rtc_update_engine_test.sv
module rtc_update_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, set_freeze = 1'b0, bin_mode = 1'b1, hr24 = 1'b1, dst_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0, rd_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       alarm_pulse, update_done;

  int n_chk = 0, n_err = 0;
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  logic [7:0] a_s = 8'hFF, a_m = 8'hFF, a_h = 8'hFF;

  always #4 clk = ~clk;

  rtc_update_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_freeze(set_freeze),
    .bin_mode(bin_mode), .hr24(hr24), .dst_en(dst_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_pulse(alarm_pulse), .update_done(update_done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int v);
    return bin_mode ? 8'(v) : 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic logic [7:0] ench(input int h);
    logic [7:0] c;
    int h12;
    if (hr24) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    c = enc(h12);
    return {(h >= 12) ? 1'b1 : 1'b0, c[6:0]};
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] exp_img();
    return {enc(m_sec), enc(m_min), ench(m_hr), enc(m_dow), enc(m_date), enc(m_mon), enc(m_yr)};
  endfunction

  function automatic logic exp_alarm();
    logic ms, mm, mh;
    ms = (a_s[7:6] == 2'b11) || (a_s == enc(m_sec));
    mm = (a_m[7:6] == 2'b11) || (a_m == enc(m_min));
    mh = (a_h[7:6] == 2'b11) || (a_h == ench(m_hr));
    return ms && mm && mh;
  endfunction

  task automatic madv();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          if (m_date == dim(m_mon, m_yr)) begin
            m_date = 1;
            if (m_mon == 12) begin m_mon = 1; m_yr = (m_yr == 99) ? 0 : m_yr + 1; end
            else m_mon++;
          end else m_date++;
        end
      end
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic rd_img(output logic [55:0] v);
    logic [7:0] b0, b2, b4, b6, b7, b8, b9;
    rd(4'd0, b0); rd(4'd2, b2); rd(4'd4, b4); rd(4'd6, b6);
    rd(4'd7, b7); rd(4'd8, b8); rd(4'd9, b9);
    v = {b0, b2, b4, b6, b7, b8, b9};
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #0.5;
  endtask

  task automatic load_time(input int h, input int mi, input int s, input int dw,
                           input int dt, input int mo, input int y);
    m_hr = h; m_min = mi; m_sec = s; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
    @(negedge clk); set_freeze = 1'b1;
    wr(4'd0, enc(s)); wr(4'd2, enc(mi)); wr(4'd4, ench(h)); wr(4'd6, enc(dw));
    wr(4'd7, enc(dt)); wr(4'd8, enc(mo)); wr(4'd9, enc(y));
    @(negedge clk); set_freeze = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_alarms(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h);
    a_s = s; a_m = mi; a_h = h;
    wr(4'd1, s); wr(4'd3, mi); wr(4'd5, h);
  endtask

  task automatic tick_chk(input string tag);
    logic [55:0] v;
    logic up, al;
    do_tick();
    up = update_done; al = alarm_pulse;
    madv();
    check("R8 update_done", 64'(up), 64'd1);
    check("R9 alarm_pulse", 64'(al), 64'(exp_alarm()));
    rd_img(v);
    check(tag, 64'(v), 64'(exp_img()));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [55:0] v, frozen;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R13 reset image and quiet pulses
    rd_img(v);
    check("R13 reset bytes", 64'(v), 64'h00_00_00_01_01_01_00);
    check("R13 pulses", {62'd0, update_done, alarm_pulse}, 64'd0);

    // R12 unused addresses
    wr(4'd11, 8'h5A);
    rd(4'd11, b); check("R12 addr 11", 64'(b), 64'd0);
    rd(4'd14, b); check("R12 addr 14", 64'(b), 64'd0);

    // R1 R2 R9: binary 24h sweep across midnight and new year
    bin_mode = 1'b1; hr24 = 1'b1;
    set_alarms(8'h05, 8'hC0, 8'hFF);
    rd(4'd1, b); check("R12 alarm write while running", 64'(b), 64'h05);
    load_time(23, 58, 0, 7, 31, 12, 99);
    for (int i = 0; i < 3700; i++) tick_chk("R1 time binary");

    // R4 R5: BCD 12h across noon, single exact alarm at 12:00:10 PM
    bin_mode = 1'b0; hr24 = 1'b0;
    set_alarms(8'h10, 8'h00, 8'h92);
    load_time(11, 58, 0, 2, 14, 6, 45);
    for (int i = 0; i < 3700; i++) tick_chk("R4 R5 time bcd 12h");

    // R5: 12h across midnight, alarm every second
    set_alarms(8'hFF, 8'hFF, 8'hFF);
    load_time(23, 58, 0, 3, 9, 3, 20);
    for (int i = 0; i < 150; i++) tick_chk("R5 midnight 12h");

    // R2 R3: month-end sweep, both encodings, leap and non-leap years
    hr24 = 1'b1;
    for (int y = 3; y <= 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        bin_mode = m[0];
        load_time(23, 59, 59, 3, dim(m, y), m, y);
        tick_chk((m == 2) ? "R3 february end" : "R2 month end");
      end
    end
    bin_mode = 1'b1;
    load_time(23, 59, 59, 5, 28, 2, 4);
    tick_chk("R3 leap feb 28");
    load_time(23, 59, 59, 5, 28, 2, 5);
    tick_chk("R3 non-leap feb 28");

    // R6: freeze without writes, internal keeps counting
    load_time(10, 0, 0, 2, 3, 5, 10);
    rd_img(frozen);
    @(negedge clk); set_freeze = 1'b1;
    for (int i = 0; i < 5; i++) begin
      do_tick();
      check("R6 no update while frozen", {62'd0, update_done, alarm_pulse}, 64'd0);
      rd_img(v);
      check("R6 frozen image", 64'(v), 64'(frozen));
      madv();
    end
    @(negedge clk); set_freeze = 1'b0;
    @(negedge clk);
    tick_chk("R6 internal kept advancing");

    // R7: write during freeze, release loads, next tick advances
    @(negedge clk); set_freeze = 1'b1;
    wr(4'd0, 8'd32);
    do_tick(); do_tick();
    @(negedge clk); set_freeze = 1'b0;
    @(negedge clk);
    m_sec = 32;
    tick_chk("R7 load then advance");

    // R7: time write ignored while running
    wr(4'd2, 8'd42);
    #0.5; rd_img(v);
    check("R7 running write ignored", 64'(v), 64'(exp_img()));

    // R12: seconds bit 7 reads 0
    @(negedge clk); set_freeze = 1'b1;
    wr(4'd0, 8'hB5);
    rd(4'd0, b); check("R12 seconds bit7", 64'(b), 64'h35);
    @(negedge clk); set_freeze = 1'b0;
    @(negedge clk);

    // R10: spring forward
    dst_en = 1'b1;
    load_time(1, 59, 59, 1, 5, 4, 30);
    do_tick(); rd_img(v);
    check("R10 spring jump", 64'(v), 64'h00_00_03_01_05_04_1E);
    load_time(1, 59, 59, 1, 12, 4, 30);
    do_tick(); rd_img(v);
    check("R10 second sunday no jump", 64'(v), 64'h00_00_02_01_0C_04_1E);
    dst_en = 1'b0;
    load_time(1, 59, 59, 1, 5, 4, 30);
    do_tick(); rd_img(v);
    check("R10 disabled no jump", 64'(v), 64'h00_00_02_01_05_04_1E);

    // R11: autumn fallback once, rearmed at midnight
    dst_en = 1'b1;
    load_time(1, 59, 59, 1, 28, 10, 30);
    do_tick(); rd_img(v);
    check("R11 fallback", 64'(v), 64'h00_00_01_01_1C_0A_1E);
    for (int i = 0; i < 3600; i++) do_tick();
    rd_img(v);
    check("R11 no second fallback", 64'(v), 64'h00_00_02_01_1C_0A_1E);
    load_time(23, 59, 59, 7, 27, 10, 30);
    do_tick(); rd_img(v);
    check("R11 midnight into sunday", 64'(v), 64'h00_00_00_01_1C_0A_1E);
    load_time(1, 59, 59, 1, 28, 10, 30);
    do_tick(); rd_img(v);
    check("R11 rearmed after midnight", 64'(v), 64'h00_00_01_01_1C_0A_1E);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule